// File: doc/BRIEF.md
# Credit-Gated Central Switch Arbiter

This block is the central arbiter of an N-port switch. Ingress ports ask for permission to move one frame toward one named egress port. The arbiter keeps a credit count of free buffer slots at every egress. It grants a request only when that egress still has a credit, and each grant uses up one credit. The egress hands the credit back with a return pulse when it has drained a buffer slot. Because of this, no frame is ever sent across the crossbar toward a full egress.

A request toward an egress with no credits is not refused. It stays pending until the egress frees a slot. Each ingress/egress pair may hold only a bounded number of pending requests. A request beyond that bound is answered with a combinational busy flag, and the ingress must present it again later. The cap keeps a heavily backlogged source from building up a long run of grants ahead of a lightly loaded one. A per-egress round-robin pointer then shares each egress evenly among the sources that are pending toward it.

Top module: `credit_arbiter`

## Requirements
- R1: After reset every egress holds EGR_DEPTH credits, no pair has pending requests, all round-robin pointers are 0, and gnt_valid_o, crd_err_o and req_busy_o are all low.
- R2: A grant toward egress e is issued only while e has at least one credit, and each grant takes one credit. Once e has granted EGR_DEPTH times with no return, it grants nothing more.
- R3: A request toward an egress with no credits stays pending. It is granted in the cycle after a credit return to that egress is sampled.
- R4: Each ingress/egress pair holds at most MAX_PEND pending requests. req_busy_o[i] is high in the same cycle while req_valid_i[i] is high and the pair (i, req_dst_i[i]) already holds MAX_PEND. A refused request is not stored.
- R5: Among the ingresses pending toward one egress, the grant goes to the first one found at or after that egress's round-robin pointer, scanning in ascending index with wrap-around. The pointer then moves to one past the granted ingress.
- R6: In any cycle each egress grants at most once and each ingress receives at most one grant. Egresses are allocated in ascending index order, and an ingress that has already won in this cycle is skipped by the higher egresses.
- R7: A credit return and a grant for the same egress in the same cycle leave that egress's credit count unchanged.
- R8: A credit return to an egress that already holds EGR_DEPTH credits, with no grant to that egress in the same cycle, raises crd_err_o[e] for one cycle in the next cycle. The count stays at EGR_DEPTH.
- R9: A request accepted at a clock edge onto an idle egress that has credits shows up on gnt_valid_o/gnt_dst_o right after the following edge. gnt_dst_o[i] carries the egress index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_PORTS | Request strobe per ingress, one request per high cycle |
| req_dst_i | input | N_PORTS x PW | Egress index of each ingress's request |
| req_busy_o | output | N_PORTS | Request refused, pair already at MAX_PEND |
| crd_ret_i | input | N_PORTS | Buffer-freed pulse per egress |
| gnt_valid_o | output | N_PORTS | Grant to ingress i this cycle |
| gnt_dst_o | output | N_PORTS x PW | Egress index of the grant |
| crd_err_o | output | N_PORTS | Credit overflow flag per egress |

## Verification
req_busy_o is combinational, so the bench checks it in the same cycle as the request, a short time after driving the inputs. A request sampled at edge t joins the pending state. The grant decision is made from that state during the next cycle, and it shows on gnt_valid_o/gnt_dst_o after edge t+1. A credit return sampled at edge t is counted at that same edge, so a held request can be granted in the next decision, with crd_err_o due after edge t. The reference model advances its state at each rising edge using the inputs held there. The registered outputs are compared at the following falling edge, and every requirement's phase is labelled in the messages.

// File: rtl/credit_arb_pkg.sv
package credit_arb_pkg;
  function automatic int wrap_inc(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/pend_counter.sv
module pend_counter #(
  parameter int MAX_PEND = 2,
  parameter int PCW      = $clog2(MAX_PEND + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic full_o,
  output logic nz_o
);
  logic [PCW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (inc_i && !dec_i) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i) cnt_q <= cnt_q - 1'b1;
  end

  assign full_o = (cnt_q >= PCW'(MAX_PEND));
  assign nz_o   = (cnt_q != '0);
endmodule

// File: rtl/egress_credit.sv
module egress_credit #(
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ret_i,
  input  logic          take_i,
  output logic [CW-1:0] cnt_o,
  output logic          avail_o,
  output logic          err_o
);
  logic [CW-1:0] cnt_q;
  logic          ovf;

  assign ovf = ret_i && !take_i && (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CW'(DEPTH);
      err_o <= 1'b0;
    end else begin
      err_o <= ovf;
      if (ret_i && !take_i && !ovf) cnt_q <= cnt_q + 1'b1;
      else if (take_i && !ret_i)    cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign avail_o = (cnt_q != '0);
endmodule

// File: rtl/grant_select.sv
module grant_select #(
  parameter int N  = 4,
  parameter int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0][N-1:0] elig_i,   // [egress][ingress]
  output logic [N-1:0][N-1:0] gnt_o     // [egress][ingress]
);
  import credit_arb_pkg::*;

  logic [N-1:0][PW-1:0] ptr_q, ptr_d;

  always_comb begin
    logic [N-1:0] taken;
    logic         found;
    int           idx;
    taken = '0;
    gnt_o = '0;
    ptr_d = ptr_q;
    for (int e = 0; e < N; e++) begin
      found = 1'b0;
      for (int k = 0; k < N; k++) begin
        idx = int'(ptr_q[e]) + k;
        if (idx >= N) idx = idx - N;
        if (!found && elig_i[e][idx] && !taken[idx]) begin
          found         = 1'b1;
          taken[idx]    = 1'b1;
          gnt_o[e][idx] = 1'b1;
          ptr_d[e]      = PW'(wrap_inc(idx, N));
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end
endmodule

// File: rtl/credit_arbiter.sv
module credit_arbiter #(
  parameter int N_PORTS   = 4,
  parameter int MAX_PEND  = 2,
  parameter int EGR_DEPTH = 4,
  localparam int PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  localparam int CW = $clog2(EGR_DEPTH + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_PORTS-1:0]         req_valid_i,
  input  logic [N_PORTS-1:0][PW-1:0] req_dst_i,
  output logic [N_PORTS-1:0]         req_busy_o,
  input  logic [N_PORTS-1:0]         crd_ret_i,
  output logic [N_PORTS-1:0]         gnt_valid_o,
  output logic [N_PORTS-1:0][PW-1:0] gnt_dst_o,
  output logic [N_PORTS-1:0]         crd_err_o
);
  logic [N_PORTS-1:0][N_PORTS-1:0] pair_full;  // [ingress][egress]
  logic [N_PORTS-1:0][N_PORTS-1:0] pair_nz;    // [ingress][egress]
  logic [N_PORTS-1:0][N_PORTS-1:0] elig;       // [egress][ingress]
  logic [N_PORTS-1:0][N_PORTS-1:0] gnt_mat;    // [egress][ingress]
  logic [N_PORTS-1:0]              egr_avail, egr_take;
  logic [N_PORTS-1:0][CW-1:0]      crd_cnt;
  logic [N_PORTS-1:0]              gv_d;
  logic [N_PORTS-1:0][PW-1:0]      gd_d;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_ing
    assign req_busy_o[i] = req_valid_i[i] && pair_full[i][req_dst_i[i]];
    for (genvar e = 0; e < N_PORTS; e++) begin : g_egr
      pend_counter #(.MAX_PEND(MAX_PEND)) u_pend (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .inc_i (req_valid_i[i] && (req_dst_i[i] == PW'(e)) && !pair_full[i][e]),
        .dec_i (gnt_mat[e][i]),
        .full_o(pair_full[i][e]),
        .nz_o  (pair_nz[i][e])
      );
      assign elig[e][i] = pair_nz[i][e] && egr_avail[e];
    end
  end

  for (genvar e = 0; e < N_PORTS; e++) begin : g_crd
    assign egr_take[e] = |gnt_mat[e];
    egress_credit #(.DEPTH(EGR_DEPTH)) u_crd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ret_i  (crd_ret_i[e]),
      .take_i (egr_take[e]),
      .cnt_o  (crd_cnt[e]),
      .avail_o(egr_avail[e]),
      .err_o  (crd_err_o[e])
    );
  end

  grant_select #(.N(N_PORTS)) u_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .elig_i(elig),
    .gnt_o (gnt_mat)
  );

  always_comb begin
    gv_d = '0;
    gd_d = '0;
    for (int i = 0; i < N_PORTS; i++)
      for (int e = 0; e < N_PORTS; e++)
        if (gnt_mat[e][i]) begin
          gv_d[i] = 1'b1;
          gd_d[i] = PW'(e);
        end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_valid_o <= '0;
      gnt_dst_o   <= '0;
    end else begin
      gnt_valid_o <= gv_d;
      gnt_dst_o   <= gd_d;
    end
  end
endmodule

// File: rtl/credit_arb_checker.sv
module credit_arb_checker #(
  parameter int N     = 4,
  parameter int DEPTH = 4,
  parameter int PW    = 2,
  parameter int CW    = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N-1:0]        gnt_valid_o,
  input logic [N-1:0][PW-1:0] gnt_dst_o,
  input logic [N-1:0]        crd_ret_i,
  input logic [N-1:0]        crd_err_o,
  input logic [N-1:0][CW-1:0] crd_cnt,
  input logic [N-1:0]        egr_take
);
  logic dup_egr;
  always_comb begin
    dup_egr = 1'b0;
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++)
        if (gnt_valid_o[a] && gnt_valid_o[b] && gnt_dst_o[a] == gnt_dst_o[b])
          dup_egr = 1'b1;
  end

  a_r6_one_grant_per_egress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dup_egr);

  for (genvar e = 0; e < N; e++) begin : g_e
    a_r8_credit_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      crd_cnt[e] <= CW'(DEPTH));
    a_r8_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      crd_err_o[e] |-> ($past(crd_ret_i[e]) && $past(crd_cnt[e]) == CW'(DEPTH)));
    a_r7_ret_take_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (crd_ret_i[e] && egr_take[e]) |=> $stable(crd_cnt[e]));
    a_r2_take_needs_credit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      egr_take[e] |-> (crd_cnt[e] != '0));
  end
endmodule

bind credit_arbiter credit_arb_checker #(
  .N(N_PORTS), .DEPTH(EGR_DEPTH), .PW(PW), .CW(CW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gnt_valid_o(gnt_valid_o),
  .gnt_dst_o  (gnt_dst_o),
  .crd_ret_i  (crd_ret_i),
  .crd_err_o  (crd_err_o),
  .crd_cnt    (crd_cnt),
  .egr_take   (egr_take)
);

// File: tb/credit_arbiter_bench.sv
module credit_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int MP  = 2;
  localparam int DEP = 3;
  localparam int PW  = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]         req_valid = '0;
  logic [N-1:0][PW-1:0] req_dst = '0;
  logic [N-1:0]         crd_ret = '0;
  logic [N-1:0]         req_busy, gnt_valid, crd_err;
  logic [N-1:0][PW-1:0] gnt_dst;

  always #(CLK_PERIOD/2) clk = ~clk;

  credit_arbiter #(.N_PORTS(N), .MAX_PEND(MP), .EGR_DEPTH(DEP)) u_credit_arbiter (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_dst_i(req_dst), .req_busy_o(req_busy),
    .crd_ret_i(crd_ret), .gnt_valid_o(gnt_valid), .gnt_dst_o(gnt_dst),
    .crd_err_o(crd_err)
  );

  int checks = 0, errors = 0;
  string tag = "R1";

  // reference model
  int m_pend [N][N];  // [ingress][egress]
  int m_cred [N];
  int m_ptr  [N];
  bit exp_gv [N];
  int exp_gd [N];
  bit exp_err[N];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_cred[i] = DEP; m_ptr[i] = 0; exp_gv[i] = 0; exp_gd[i] = 0; exp_err[i] = 0;
      for (int e = 0; e < N; e++) m_pend[i][e] = 0;
    end
  endtask

  task automatic model_edge();
    bit taken[N];
    bit acc[N];
    bit took[N];
    for (int i = 0; i < N; i++) begin
      taken[i] = 0; exp_gv[i] = 0; exp_gd[i] = 0;
      acc[i] = req_valid[i] && (m_pend[i][req_dst[i]] < MP);
    end
    for (int e = 0; e < N; e++) begin
      took[e] = 0;
      if (m_cred[e] > 0)
        for (int k = 0; k < N; k++) begin
          int c = (m_ptr[e] + k) % N;
          if (!took[e] && !taken[c] && m_pend[c][e] > 0) begin
            took[e] = 1; taken[c] = 1;
            exp_gv[c] = 1; exp_gd[c] = e;
            m_pend[c][e]--;
            m_ptr[e] = (c + 1) % N;
          end
        end
    end
    for (int e = 0; e < N; e++) begin
      exp_err[e] = crd_ret[e] && !took[e] && m_cred[e] == DEP;
      if (took[e]) m_cred[e]--;
      if (crd_ret[e] && !exp_err[e]) m_cred[e]++;
    end
    for (int i = 0; i < N; i++) if (acc[i]) m_pend[i][req_dst[i]]++;
  endtask

  task automatic tick();
    #1;
    for (int i = 0; i < N; i++)
      chk("R4", $sformatf("busy[%0d]", i), int'(req_busy[i]),
          int'(req_valid[i] && m_pend[i][req_dst[i]] >= MP));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      chk(tag, $sformatf("gnt_valid[%0d]", i), int'(gnt_valid[i]), int'(exp_gv[i]));
      if (exp_gv[i]) chk(tag, $sformatf("gnt_dst[%0d]", i), int'(gnt_dst[i]), exp_gd[i]);
      chk("R8", $sformatf("crd_err[%0d]", i), int'(crd_err[i]), int'(exp_err[i]));
    end
  endtask

  task automatic idle(input int n);
    req_valid = '0; crd_ret = '0;
    for (int k = 0; k < n; k++) tick();
  endtask

  bit done = 0;
  initial begin
    for (int k = 0; k < 20000; k++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1", "gnt_valid in reset", int'(gnt_valid), 0);
    chk("R1", "crd_err in reset", int'(crd_err), 0);
    chk("R1", "busy in reset", int'(req_busy), 0);
    rst_ni = 1'b1;
    tag = "R1"; idle(2);

    // R9: single request, grant one edge later
    tag = "R9";
    req_valid = 4'b0001; req_dst[0] = 2'd1; tick();
    req_valid = '0; tick();
    idle(2);

    // R2/R4: ingress 0 hammers egress 3 until credits are gone and pair fills
    tag = "R2";
    req_dst[0] = 2'd3;
    for (int k = 0; k < 8; k++) begin req_valid = 4'b0001; tick(); end
    req_valid = '0; idle(2);

    // R3: returned credit releases a held request
    tag = "R3";
    crd_ret = 4'b1000; tick();
    crd_ret = '0; idle(2);

    // R7: return and grant on egress 3 in the same cycle
    tag = "R7";
    crd_ret = 4'b1000; tick();
    crd_ret = 4'b1000; tick();
    crd_ret = '0; idle(2);
    crd_ret = 4'b1000;
    for (int k = 0; k < 4; k++) tick();
    crd_ret = '0; idle(2);

    // R5: heavy and light sources toward egress 0
    tag = "R5";
    req_dst = '0;
    for (int k = 0; k < 10; k++) begin
      req_valid = (k < 8) ? 4'b0001 : 4'b0000;
      if (k == 1) req_valid = 4'b0101;
      if (k == 2) req_valid = 4'b1011;
      crd_ret[0] = (k >= 2);
      tick();
    end
    crd_ret = '0; idle(3);

    // R6: contention across egresses, same ingress wins lower egress first
    tag = "R6";
    for (int k = 0; k < 12; k++) begin
      for (int i = 0; i < N; i++) req_dst[i] = PW'((i + k) % 2);
      req_valid = 4'b1111;
      crd_ret = 4'b0011;
      tick();
    end
    req_valid = '0; crd_ret = 4'b0011;
    for (int k = 0; k < 6; k++) tick();
    crd_ret = '0; idle(2);

    // R8: return onto a full egress
    tag = "R8";
    crd_ret = 4'b0100; tick();
    crd_ret = '0; tick();
    crd_ret = 4'b1111; tick();
    crd_ret = '0; idle(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule